// File: doc/BRIEF.md
# SPI Controller with Byte Queues

This block moves bytes over a four-wire serial link, either as the clock-driving master or as a slave that follows an external clock. All four clock polarity and phase combinations are supported, and bytes are sent most-significant bit first. Software talks to the block through four byte-wide registers. Writes to the data register put bytes into a transmit queue, and reads from it take bytes out of a receive queue. Each queue holds eight bytes when queue mode is on and a single byte when it is off.

Two interrupt sources support bulk transfers driven by software. One asks for more transmit data once the transmit queue has drained to half its size or below. The other reports that a received byte is waiting. A framing bit controls chip select. When it is clear, select must rise between bytes. When it is set, select may stay low across a burst: a master keeps it low while its queue has data, and a slave tied permanently low finds byte boundaries by counting clock edges.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: After reset the status register reads 0x02 (only "transmit empty" set), irq is low, cs_n_o is high and sclk_o is low.
- R2: Register addresses: 0 is control, 1 is clock divider, 2 is data (write pushes a transmit byte, read pops a receive byte), 3 is status. Control bits: 0 enable, 1 master, 2 clock polarity, 3 clock phase, 4 queue mode, 5 multi-byte select, 6 transmit-half interrupt enable, 7 receive-data interrupt enable. Registers 0 and 1 read back what was written.
- R3: In master mode each byte is shifted MSB first in the selected mode, and looped-back data is received unchanged. sclk_o idles at the polarity level. One byte holds cs_n_o low for 16*(divider+1) clock cycles.
- R4: As master, with multi-byte select set, cs_n_o stays low across all queued bytes (one rising edge per burst). With it clear, cs_n_o rises after every byte.
- R5: The queue capacity is 8 bytes in queue mode and 1 byte otherwise. Status bits: 0 transmit full, 1 transmit empty, 2 receive not empty, 3 receive full, 7 master busy.
- R6: A data write to a full transmit queue is dropped and sets sticky status bit 4. Writing a 1 to status bit 4 clears it.
- R7: A byte that completes while the receive queue is full is discarded, the queue contents are kept, and sticky status bit 5 is set. Writing a 1 to bit 5 clears it.
- R8: As slave with multi-byte select clear, bytes are exchanged only while cs_n_i is low. After one byte, further clock edges are ignored until cs_n_i has risen, and clock edges with cs_n_i high are ignored.
- R9: As slave with multi-byte select set, cs_n_i may be held low permanently, and every eight sampling edges form one byte in all four modes.
- R10: When a slave must send a byte while its transmit queue is empty, it sends 0x00 and sets sticky status bit 6. Writing a 1 to bit 6 clears it.
- R11: With control bit 6 set, irq is high whenever the transmit level is at most half the capacity (4 of 8 in queue mode, 0 of 1 otherwise).
- R12: With control bit 7 set, irq is high whenever the receive queue holds at least one byte.
- R13: With enable clear, no transfer starts, queued transmit bytes stay queued and cs_n_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the receive queue at address 2) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sclk_i | input | 1 | Serial clock from the external master (slave mode) |
| cs_n_i | input | 1 | Active-low select from the external master (slave mode) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sclk_o | output | 1 | Serial clock driven in master mode |
| cs_n_o | output | 1 | Active-low select driven in master mode |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs all four clock modes as master in loopback, and as slave both with select toggled per byte and with select tied low. A mix-up in sampling and shifting edges would garble bits or lose the first bit of each byte. It sweeps the transmit level from 0 to 8 against the half-full interrupt threshold, where an off-by-one design fires at five bytes or stays silent at four. It pushes one byte past each queue's capacity, where a design without a drop would overwrite stored data. It clocks a slave past the end of a byte without lifting select, where a design that does not lock would take a second byte. It also runs a slave with an empty queue to confirm the zero filler and the underrun flag.

// File: rtl/spi_fifo_ctrl.sv
`timescale 1ns/1ps
module spi_fifo_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       sdi,
  output logic       sclk_o,
  output logic       cs_n_o,
  output logic       sdo,
  output logic       irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [7:0] ctrl, div;
  logic [7:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0] sr, rxs, pc;
  logic [2:0] cnt;
  logic [3:0] tc;
  logic pend, locked, ovf, ovr, udr, busy, sclk_r, sclk_d, act_d;
  logic [1:0] s_sclk, s_cs, s_sdi;

  wire en = ctrl[0], mst = ctrl[1], cpol = ctrl[2], cpha = ctrl[3];
  wire fen = ctrl[4], multi = ctrl[5], tie = ctrl[6], rie = ctrl[7];

  wire [CW-1:0] cap = fen ? CW'(DEPTH) : CW'(1);
  wire tx_full = tx_cnt == cap;
  wire tx_emp  = tx_cnt == '0;
  wire rx_full = rx_cnt == cap;
  wire rx_ne   = rx_cnt != '0;

  wire tick    = busy && pc == div;
  wire s_act   = en && !mst && !s_cs[1];
  wire s_edge  = s_act && !locked && (s_sclk[1] != sclk_d);
  wire lead    = mst ? (tick && !tc[0]) : (s_edge && s_sclk[1] != cpol);
  wire trail   = mst ? (tick &&  tc[0]) : (s_edge && s_sclk[1] == cpol);
  wire samp    = cpha ? trail : lead;
  wire shev    = cpha ? lead : trail;
  wire sdi_v   = mst ? sdi : s_sdi[1];
  wire bdone   = samp && cnt == 3'd7;
  wire s_start = s_act && !act_d;
  wire m_start = en && mst && !busy && !tx_emp;
  wire m_end   = tick && tc == 4'd15;
  wire m_cont  = m_end && multi && !tx_emp;
  wire load    = m_start || m_cont || (!mst && ((s_start && !cpha) || (shev && pend)));

  wire wr_dat  = wr_en && wr_addr == 2'd2;
  wire push_tx = wr_dat && !tx_full;
  wire pop_tx  = load && !tx_emp;
  wire push_rx = bdone && !rx_full;
  wire pop_rx  = rd_en && rd_addr == 2'd2 && rx_ne;

  always_ff @(posedge clk) begin
    if (push_tx) txm[tx_wp] <= wr_data;
    if (push_rx) rxm[rx_wp] <= {rxs[6:0], sdi_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; div <= '0; ovf <= 1'b0; ovr <= 1'b0; udr <= 1'b0;
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt <= '0; rx_cnt <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd0) ctrl <= wr_data;
      if (wr_en && wr_addr == 2'd1) div <= wr_data;
      if (wr_en && wr_addr == 2'd3) begin
        if (wr_data[4]) ovf <= 1'b0;
        if (wr_data[5]) ovr <= 1'b0;
        if (wr_data[6]) udr <= 1'b0;
      end
      if (wr_dat && tx_full) ovf <= 1'b1;
      if (bdone && rx_full) ovr <= 1'b1;
      if (load && tx_emp && !mst) udr <= 1'b1;
      if (push_tx) tx_wp <= tx_wp + 1'b1;
      if (pop_tx)  tx_rp <= tx_rp + 1'b1;
      if (push_rx) rx_wp <= rx_wp + 1'b1;
      if (pop_rx)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(push_tx) - CW'(pop_tx);
      rx_cnt <= rx_cnt + CW'(push_rx) - CW'(pop_rx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0; s_cs <= 2'b11; s_sdi <= '0; sclk_d <= 1'b0; act_d <= 1'b0;
      busy <= 1'b0; pc <= '0; tc <= '0; sclk_r <= 1'b0;
      sr <= '0; rxs <= '0; cnt <= '0; pend <= 1'b0; locked <= 1'b0;
    end else begin
      s_sclk <= {s_sclk[0], sclk_i};
      s_cs   <= {s_cs[0], cs_n_i};
      s_sdi  <= {s_sdi[0], sdi};
      sclk_d <= s_sclk[1];
      act_d  <= s_act;
      if (!en) begin
        busy <= 1'b0; pc <= '0; tc <= '0; sclk_r <= cpol;
        cnt <= '0; pend <= 1'b0; locked <= 1'b0;
      end else begin
        if (!busy) sclk_r <= cpol;
        if (m_start) begin
          busy <= 1'b1; pc <= '0; tc <= '0;
        end
        if (busy) begin
          pc <= tick ? '0 : pc + 8'd1;
          if (tick) begin
            sclk_r <= ~sclk_r;
            tc <= tc + 4'd1;
          end
          if (m_end && !m_cont) busy <= 1'b0;
        end
        if (samp) begin
          rxs <= {rxs[6:0], sdi_v};
          cnt <= cnt + 3'd1;
        end
        if (bdone && !mst) begin
          if (multi) pend <= 1'b1;
          else locked <= 1'b1;
        end
        if (load) begin
          sr <= tx_emp ? 8'h00 : txm[tx_rp];
          pend <= 1'b0;
        end else if (shev && cnt != 3'd0) begin
          sr <= {sr[6:0], 1'b0};
        end
        if (!mst && s_start && cpha) pend <= 1'b1;
        if (!mst && s_cs[1]) begin
          cnt <= '0; pend <= 1'b0; locked <= 1'b0;
        end
      end
    end
  end

  assign sclk_o = sclk_r;
  assign cs_n_o = !(mst && busy);
  assign sdo    = sr[7];
  assign irq    = (tie && tx_cnt <= (cap >> 1)) || (rie && rx_ne);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl;
      2'd1:    rd_data = div;
      2'd2:    rd_data = rxm[rx_rp];
      default: rd_data = {busy, udr, ovr, ovf, rx_full, rx_ne, tx_emp, tx_full};
    endcase
  end
endmodule

// File: rtl/spi_fifo_chk.sv
`timescale 1ns/1ps
module spi_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       tx_full,
  input logic       tx_emp,
  input logic       rx_full,
  input logic       rx_ne,
  input logic       bdone,
  input logic       load,
  input logic       mst,
  input logic       en,
  input logic       cpol,
  input logic       ovf,
  input logic       ovr,
  input logic       udr,
  input logic       cs_n_o,
  input logic       sclk_o
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && tx_full) |=> ovf);

  assert_rx_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bdone && !rx_full) |=> rx_ne);

  assert_rx_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bdone && rx_full) |=> ovr);

  assert_underrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tx_emp && !mst) |=> udr);

  assert_quiet_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cs_n_o);

  assert_clock_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && $stable(cpol)) |-> sclk_o == cpol);
endmodule

bind spi_fifo_ctrl spi_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .tx_full(tx_full), .tx_emp(tx_emp), .rx_full(rx_full), .rx_ne(rx_ne),
  .bdone(bdone), .load(load), .mst(mst), .en(en), .cpol(cpol),
  .ovf(ovf), .ovr(ovr), .udr(udr), .cs_n_o(cs_n_o), .sclk_o(sclk_o)
);

// File: tb/sim_spi_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_spi_fifo_ctrl;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic sclk_i = 1'b0, cs_n_i = 1'b1, sdi_drv = 1'b0, loop = 1'b0;
  logic sdi, sclk_o, cs_n_o, sdo, irq;
  int checks = 0, errors = 0;
  int rises = 0, lowcnt = 0;
  logic prev_cs = 1'b1;
  logic [7:0] capb = '0;

  assign sdi = loop ? sdo : sdi_drv;

  always #2.5 clk = ~clk;

  spi_fifo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi(sdi),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sdo(sdo), .irq(irq)
  );

  always @(negedge clk) begin
    if (!prev_cs && cs_n_o) rises++;
    if (!cs_n_o) lowcnt++;
    prev_cs = cs_n_o;
  end

  always @(posedge sclk_o) capb = {capb[6:0], sdo};

  function automatic [7:0] pat(input int b, input int k);
    return 8'(b + k * 53 + k * k * 7 + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
    if (a == 2'd2) begin
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    end
  endtask

  task automatic widle();
    logic [7:0] s;
    bit done = 0;
    for (int i = 0; i < 4000 && !done; i++) begin
      rdreg(2'd3, s);
      if (!s[7] && s[1]) done = 1;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic mrun(input int mode, input bit multi, input int n, input int base);
    logic [7:0] c, d;
    int r0;
    c = {2'b00, multi, 1'b1, mode[0], mode[1], 1'b1, 1'b0};
    loop = 1'b1;
    wr(2'd0, c);
    for (int k = 0; k < n; k++) wr(2'd2, pat(base, k));
    r0 = rises;
    wr(2'd0, c | 8'h01);
    widle();
    chk($sformatf("R4 cs rises mode %0d multi %0d", mode, multi), rises - r0, multi ? 1 : n);
    for (int k = 0; k < n; k++) begin
      rdreg(2'd2, d);
      chk($sformatf("R3 loopback mode %0d byte %0d", mode, k), d, pat(base, k));
    end
    wr(2'd0, c);
  endtask

  task automatic sx(input logic [7:0] tx, input bit cpha, output logic [7:0] got);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        sdi_drv = tx[i];
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i; got = {got[6:0], sdo};
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i;
      end else begin
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i; sdi_drv = tx[i];
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i; got = {got[6:0], sdo};
      end
    end
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d, got, c;
    int l0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rdreg(2'd3, s);
    chk("R1 status", s, 8'h02);
    chk("R1 irq", irq, 0);
    chk("R1 cs_n_o", cs_n_o, 1);
    chk("R1 sclk_o", sclk_o, 0);

    wr(2'd1, 8'h01);
    rdreg(2'd1, s); chk("R2 divider readback", s, 8'h01);
    wr(2'd0, 8'h3A);
    rdreg(2'd0, s); chk("R2 control readback", s, 8'h3A);

    for (int m = 0; m < 4; m++) mrun(m, 1'b1, 3, m * 40);
    mrun(3, 1'b0, 2, 17);
    mrun(1, 1'b0, 3, 77);

    wr(2'd1, 8'h02);
    l0 = lowcnt;
    mrun(0, 1'b0, 1, 200);
    chk("R3 cs low cycles div 2", lowcnt - l0, 48);
    chk("R3 msb first on sdo", capb, pat(200, 0));
    chk("R3 sclk idles at polarity", sclk_o, 0);
    wr(2'd1, 8'h01);

    wr(2'd0, 8'h72);
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) wr(2'd2, pat(7, k - 1));
      chk($sformatf("R11 half irq level %0d", k), irq, (k <= 4) ? 1 : 0);
      rdreg(2'd3, s);
      chk($sformatf("R5 tx full level %0d", k), s[0], (k == 8) ? 1 : 0);
    end
    wr(2'd2, 8'hEE);
    rdreg(2'd3, s); chk("R6 overflow flag", s[4], 1);
    wr(2'd3, 8'h10);
    rdreg(2'd3, s); chk("R6 overflow cleared", s[4], 0);
    loop = 1'b1;
    wr(2'd0, 8'h73);
    widle();
    rdreg(2'd3, s);
    chk("R5 rx full after 8", s[3], 1);
    chk("R7 no overrun yet", s[5], 0);
    wr(2'd2, 8'h99);
    widle();
    rdreg(2'd3, s); chk("R7 overrun flag", s[5], 1);
    wr(2'd0, 8'hB3);
    chk("R12 irq with rx data", irq, 1);
    for (int k = 0; k < 8; k++) begin
      rdreg(2'd2, d);
      chk($sformatf("R7 rx kept byte %0d", k), d, pat(7, k));
    end
    chk("R12 irq after drain", irq, 0);
    rdreg(2'd3, s); chk("R5 rx empty after drain", s[2], 0);
    wr(2'd3, 8'h20);
    rdreg(2'd3, s); chk("R7 overrun cleared", s[5], 0);

    wr(2'd0, 8'h02);
    wr(2'd2, 8'h3C);
    rdreg(2'd3, s); chk("R5 single-byte tx full", s[0], 1);
    wr(2'd2, 8'hC3);
    rdreg(2'd3, s); chk("R6 single-byte overflow", s[4], 1);
    wr(2'd3, 8'h10);
    repeat (40) @(negedge clk);
    chk("R13 cs stays high while disabled", cs_n_o, 1);
    rdreg(2'd3, s); chk("R13 tx still queued", s[1], 0);
    wr(2'd0, 8'h03);
    widle();
    rdreg(2'd3, s); chk("R5 single-byte rx full", s[3], 1);
    rdreg(2'd2, d); chk("R5 single-byte data", d, 8'h3C);
    wr(2'd0, 8'h42);
    chk("R11 single-byte empty irq", irq, 1);
    wr(2'd0, 8'h00);
    loop = 1'b0;

    for (int m = 0; m < 4; m++) begin
      c = {4'b0001, m[0], m[1], 2'b00};
      sclk_i = m[1]; cs_n_i = 1'b1;
      wr(2'd0, c);
      wr(2'd2, pat(m * 16, 0));
      wr(2'd2, pat(m * 16, 1));
      wr(2'd0, c | 8'h01);
      repeat (H) @(negedge clk);
      for (int j = 0; j < 2; j++) begin
        cs_n_i = 1'b0; repeat (H) @(negedge clk);
        sx(pat(m * 16 + 100, j), m[0], got);
        cs_n_i = 1'b1; repeat (H) @(negedge clk);
        chk($sformatf("R8 slave sdo mode %0d byte %0d", m, j), got, pat(m * 16, j));
      end
      for (int j = 0; j < 2; j++) begin
        rdreg(2'd2, d);
        chk($sformatf("R8 slave rx mode %0d byte %0d", m, j), d, pat(m * 16 + 100, j));
      end
      wr(2'd0, c);
    end

    sclk_i = 1'b0;
    wr(2'd0, 8'h10);
    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h11);
    cs_n_i = 1'b0; repeat (H) @(negedge clk);
    sx(8'h3E, 1'b0, got);
    sx(8'h71, 1'b0, got);
    cs_n_i = 1'b1; repeat (H) @(negedge clk);
    rdreg(2'd2, d); chk("R8 first byte kept", d, 8'h3E);
    rdreg(2'd3, s); chk("R8 extra clocks ignored", s[2], 0);
    sx(8'h0F, 1'b0, got);
    rdreg(2'd3, s); chk("R8 clocks with cs high ignored", s[2], 0);
    wr(2'd0, 8'h10);

    for (int m = 0; m < 4; m++) begin
      c = {4'b0011, m[0], m[1], 2'b00};
      sclk_i = m[1]; cs_n_i = 1'b0;
      wr(2'd0, c);
      for (int j = 0; j < 3; j++) wr(2'd2, pat(m * 9 + 3, j));
      wr(2'd0, c | 8'h01);
      repeat (H) @(negedge clk);
      for (int j = 0; j < 3; j++) begin
        sx(pat(m * 9 + 150, j), m[0], got);
        chk($sformatf("R9 multi sdo mode %0d byte %0d", m, j), got, pat(m * 9 + 3, j));
      end
      for (int j = 0; j < 3; j++) begin
        rdreg(2'd2, d);
        chk($sformatf("R9 multi rx mode %0d byte %0d", m, j), d, pat(m * 9 + 150, j));
      end
      wr(2'd0, c);
      cs_n_i = 1'b1;
    end

    sclk_i = 1'b0;
    wr(2'd0, 8'h11);
    cs_n_i = 1'b0; repeat (H) @(negedge clk);
    sx(8'h5A, 1'b0, got);
    cs_n_i = 1'b1; repeat (H) @(negedge clk);
    chk("R10 filler byte", got, 8'h00);
    rdreg(2'd3, s); chk("R10 underrun flag", s[6], 1);
    rdreg(2'd2, d); chk("R10 rx still taken", d, 8'h5A);
    wr(2'd3, 8'h40);
    rdreg(2'd3, s); chk("R10 underrun cleared", s[6], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule